// File: doc/BRIEF.md
# Farrow-Based Polyphase Integer Interpolator

This block raises the sample rate of a signed stream by a fixed integer factor M. It takes one input sample at a time. For each one it returns M output samples, in phase order, to a sink that uses ready/valid flow control. Phase 0 comes from a short symmetric (Type I linear-phase) FIR whose order is one more than the order of the shared subfilters. Phases 1 to M-1 do not each have their own FIR. They all reuse one bank of L+1 subfilter outputs, which is computed once per input sample. Each phase combines those outputs in Horner form with its own fractional delay d_m = 1/2 - m/M.

The delay values are derived from M at elaboration. Only the lower half of the table (m = 0 to M/2) is held. Phases above M/2 take the negated value of the mirrored entry. To retarget the block to another factor, change M. The subfilter and FIR coefficients are parameters and stay the same. The coefficients are assumed to be designed elsewhere.

Top module: `farrow_interp`

## Requirements
- R1: Out of reset `inRdy` is 1 and `outVld` is 0.
- R2: When a sample is accepted (`inVld && inRdy` at a rising edge), `outVld` is 1 from the next cycle. `outPhase` is 0 first and then rises by one after each accepted output (`outVld && outRdy`), up to M-1. After exactly M accepted outputs, `outVld` returns to 0.
- R3: `inRdy` is 0 for as long as any phase of the current sample is still pending. It is 1 again in the cycle after the phase M-1 output has been accepted.
- R4: The phase 0 output is (sum over k = 0..N0 of h0[k]·x[n-k]) >>> CF. Here x[n] is the newest accepted sample, samples older than reset count as 0, and h0[k] = h0[N0-k] is built by mirroring the N0/2+1 stored coefficients.
- R5: The phase m output, for m ≥ 1, is computed in Horner form as follows. Start with acc = g_L. For k = L-1 down to 0, set acc = ((acc·d_m) >>> DF) + g_k. Then output acc >>> CF. Here g_k = sum over j = 0..N1 of G[k][j]·x[n-j], and d_m = (2^DF·(M-2m))/(2M), with the division truncated toward zero. All shifts are arithmetic.
- R6: d_(M-m) = -d_m. When M is even, phase M/2 has d = 0, so its output is exactly g_0 >>> CF.
- R7: While `outVld && !outRdy`, both `outData` and `outPhase` hold their values on the next cycle.
- R8: An asserted `inVld` while `inRdy` is 0 is ignored. The offered data never enters the filter history, so the outputs of later samples are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inVld | input | 1 | Input sample offered |
| inRdy | output | 1 | Block can accept an input sample |
| inData | input | DW | Signed input sample |
| outVld | output | 1 | Output sample valid |
| outRdy | input | 1 | Sink accepts the output sample |
| outData | output | DW | Signed interpolated output sample |
| outPhase | output | 8 | Phase index of the current output sample |

## Verification
A unit impulse shows each phase's coefficient sequence one at a time. A phase-0 mismatch points at the symmetric FIR. A mismatch on the other phases points at the subfilter bank or at a delay value. A sine at a frequency that does not divide the rate then covers every tap with nonzero, changing data, including the negated upper-half delays and the zero-delay middle phase. Throughout the run, the sink's readiness and the source's offers are toggled pseudo-randomly. This separates correct stalling from dropped or repeated phases, and shows that samples offered while busy are ignored.

// File: rtl/farrow_interp_pkg.sv
package farrow_interp_pkg;
  localparam int PH_W = 8;
  typedef struct packed {
    logic            shift;
    logic [PH_W-1:0] phase;
  } farrowStrb_t;
endpackage

// File: rtl/farrow_interp_ctrl.sv
module farrow_interp_ctrl
  import farrow_interp_pkg::*;
#(
  parameter int M = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inVld,
  output logic        inRdy,
  output logic        outVld,
  input  logic        outRdy,
  output farrowStrb_t strb
);
  localparam logic [PH_W-1:0] LAST = PH_W'(M - 1);

  logic            busy;
  logic [PH_W-1:0] phase;

  assign inRdy      = !busy;
  assign outVld     = busy;
  assign strb.shift = inVld && !busy;
  assign strb.phase = phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      phase <= '0;
    end else if (strb.shift) begin
      busy  <= 1'b1;
      phase <= '0;
    end else if (busy && outRdy) begin
      if (phase == LAST) begin
        busy  <= 1'b0;
        phase <= '0;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/farrow_interp_dp.sv
module farrow_interp_dp
  import farrow_interp_pkg::*;
#(
  parameter int M    = 4,
  parameter int DW   = 16,
  parameter int CF   = 8,
  parameter int DF   = 8,
  parameter int N1   = 3,
  parameter int L    = 2,
  parameter int ACCW = 48,
  parameter int H0_HALF [(N1 + 1) / 2 + 1] = '{-8, 40, 192},
  parameter int G_COEF [L + 1][N1 + 1] = '{'{-16, 144, 144, -16},
                                           '{20, -150, 150, -20},
                                           '{30, -30, -30, 30}}
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  farrowStrb_t          strb,
  input  logic signed [DW-1:0] inData,
  output logic signed [DW-1:0] outData
);
  localparam int N0   = N1 + 1;
  localparam int NT   = N0 + 1;
  localparam int HALF = M / 2;
  localparam int DDW  = DF + 2;

  logic signed [DW-1:0]   taps [NT];
  logic signed [ACCW-1:0] gOut [L+1];
  logic signed [ACCW-1:0] h0Acc;
  logic signed [ACCW-1:0] farAcc;
  logic signed [DDW-1:0]  dHalf [HALF+1];
  logic signed [DDW-1:0]  dSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NT; i++) taps[i] <= '0;
    end else if (strb.shift) begin
      taps[0] <= inData;
      for (int i = 1; i < NT; i++) taps[i] <= taps[i-1];
    end
  end

  // Symmetric phase-0 FIR: only half of the coefficients are stored
  always_comb begin
    h0Acc = '0;
    for (int k = 0; k < NT; k++) begin
      h0Acc = h0Acc + ACCW'(taps[k]) *
              ACCW'((k <= N0 / 2) ? H0_HALF[k] : H0_HALF[N0 - k]);
    end
  end

  // Shared subfilter bank, evaluated once per input sample
  for (genvar gk = 0; gk <= L; gk++) begin : g_sub
    always_comb begin
      gOut[gk] = '0;
      for (int j = 0; j <= N1; j++) begin
        gOut[gk] = gOut[gk] + ACCW'(taps[j]) * ACCW'(G_COEF[gk][j]);
      end
    end
  end

  // Half delay table; the upper phases use the negated mirror entry
  for (genvar gm = 0; gm <= HALF; gm++) begin : g_dtab
    assign dHalf[gm] = DDW'(((1 << DF) * (M - 2 * gm)) / (2 * M));
  end

  always_comb begin
    if (int'(strb.phase) <= HALF) dSel = dHalf[int'(strb.phase) % (HALF + 1)];
    else                          dSel = -dHalf[(M - int'(strb.phase)) % (HALF + 1)];
  end

  always_comb begin
    farAcc = gOut[L];
    for (int k = L - 1; k >= 0; k--) begin
      farAcc = ((farAcc * ACCW'(dSel)) >>> DF) + gOut[k];
    end
  end

  always_comb begin
    if (strb.phase == '0) outData = DW'(h0Acc >>> CF);
    else                  outData = DW'(farAcc >>> CF);
  end
endmodule

// File: rtl/farrow_interp.sv
module farrow_interp
  import farrow_interp_pkg::*;
#(
  parameter int M    = 4,
  parameter int DW   = 16,
  parameter int CF   = 8,
  parameter int DF   = 8,
  parameter int N1   = 3,
  parameter int L    = 2,
  parameter int ACCW = 48,
  parameter int H0_HALF [(N1 + 1) / 2 + 1] = '{-8, 40, 192},
  parameter int G_COEF [L + 1][N1 + 1] = '{'{-16, 144, 144, -16},
                                           '{20, -150, 150, -20},
                                           '{30, -30, -30, 30}}
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inVld,
  output logic          inRdy,
  input  logic [DW-1:0] inData,
  output logic          outVld,
  input  logic          outRdy,
  output logic [DW-1:0] outData,
  output logic [7:0]    outPhase
);
  farrowStrb_t strb;

  farrow_interp_ctrl #(.M(M)) u_ctrl (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inRdy(inRdy),
    .outVld(outVld), .outRdy(outRdy), .strb(strb)
  );

  farrow_interp_dp #(
    .M(M), .DW(DW), .CF(CF), .DF(DF), .N1(N1), .L(L), .ACCW(ACCW),
    .H0_HALF(H0_HALF), .G_COEF(G_COEF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .inData(inData), .outData(outData)
  );

  assign outPhase = strb.phase;
endmodule

// File: rtl/farrow_interp_chk.sv
module farrow_interp_chk #(
  parameter int M  = 4,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          inVld,
  input logic          inRdy,
  input logic          outVld,
  input logic          outRdy,
  input logic [DW-1:0] outData,
  input logic [7:0]    outPhase
);
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (inVld && inRdy) |=> (outVld && outPhase == 8'd0)); // R2
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (outVld && outRdy && outPhase != 8'(M - 1)) |=> (outVld && outPhase == $past(outPhase) + 8'd1)); // R2
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    outVld |-> (outPhase < 8'(M))); // R2
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    outVld |-> !inRdy); // R3
  AST_LAST_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (outVld && outRdy && outPhase == 8'(M - 1)) |=> (inRdy && !outVld)); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outVld && !outRdy) |=> (outVld && $stable(outData) && $stable(outPhase))); // R7
endmodule

bind farrow_interp farrow_interp_chk #(.M(M), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .inVld(inVld), .inRdy(inRdy), .outVld(outVld),
  .outRdy(outRdy), .outData(outData), .outPhase(outPhase)
);

// File: tb/farrow_interp_tb.sv
module farrow_interp_tb;
  localparam int M  = 4;
  localparam int DW = 16;
  localparam int CF = 8;
  localparam int DF = 8;
  localparam int N1 = 3;
  localparam int L  = 2;
  localparam int N0 = N1 + 1;
  localparam int NS = 40;
  localparam int HH [N0/2+1] = '{-8, 40, 192};
  localparam int GC [L+1][N1+1] = '{'{-16, 144, 144, -16},
                                    '{20, -150, 150, -20},
                                    '{30, -30, -30, 30}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inVld = 1'b0;
  logic outRdy = 1'b0;
  logic [DW-1:0] inData = '0;
  logic inRdy, outVld;
  logic [DW-1:0] outData;
  logic [7:0] outPhase;

  always #2.5 clk = ~clk;

  farrow_interp #(.M(M), .DW(DW), .CF(CF), .DF(DF), .N1(N1), .L(L),
                  .H0_HALF(HH), .G_COEF(GC)) u_dut (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inRdy(inRdy), .inData(inData),
    .outVld(outVld), .outRdy(outRdy), .outData(outData), .outPhase(outPhase)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit running = 0;
  int samp [NS];
  longint hist [N0+1];
  bit mBusy = 0;
  int mPhase = 0;
  int sIdx = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit prevStall = 0;
  logic [DW-1:0] prevData = '0;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (time %0t)", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic longint dOf(int m);
    return longint'(((1 << DF) * (M - 2 * m)) / (2 * M));
  endfunction

  function automatic longint gSum(int k);
    longint s = 0;
    for (int j = 0; j <= N1; j++) s += longint'(GC[k][j]) * hist[j];
    return s;
  endfunction

  function automatic longint expOut(int m);
    longint acc;
    if (m == 0) begin
      acc = 0;
      for (int k = 0; k <= N0; k++)
        acc += longint'((k <= N0/2) ? HH[k] : HH[N0-k]) * hist[k];
      return acc >>> CF;
    end
    acc = gSum(L);
    for (int k = L - 1; k >= 0; k--) acc = ((acc * dOf(m)) >>> DF) + gSum(k);
    return acc >>> CF;
  endfunction

  initial begin
    for (int i = 0; i < NS; i++) begin
      if (i == 0) samp[i] = 1000;
      else if (i < 10) samp[i] = 0;
      else samp[i] = int'($rtoi(8000.0 * $sin(2.0 * 3.14159265 * (i - 10) / 13.0)));
    end
    for (int i = 0; i <= N0; i++) hist[i] = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 inRdy after reset", longint'(inRdy), 1);
    check("R1 outVld after reset", longint'(outVld), 0);
    // R6: delay table antisymmetry from the requirement formula
    for (int m = 1; m < M; m++) check("R6 d antisymmetry", dOf(M - m), -dOf(m));
    running = 1;
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
      finishRun();
    end
    if (running) begin
      // compare against model every clock
      check("R3 inRdy", longint'(inRdy), longint'(!mBusy));
      check("R2 outVld", longint'(outVld), longint'(mBusy));
      if (mBusy) begin
        check("R2 outPhase", longint'(outPhase), longint'(mPhase));
        check(mPhase == 0 ? "R4 phase0 data" : "R5 farrow data",
              longint'($signed(outData)), expOut(mPhase));
        if ((M % 2 == 0) && mPhase == M / 2)
          check("R6 mid phase equals g0", longint'($signed(outData)), gSum(0) >>> CF);
        if (prevStall)
          check("R7 stall hold data", longint'(outData), longint'(prevData));
      end
      if (!mBusy && sIdx == NS) finishRun();
      // drive next stimulus
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      outRdy = (lfsr[1:0] != 2'b00);
      if (mBusy) begin
        inVld = lfsr[2];              // R8: offered while busy, must be ignored
        inData = 16'h5A5A;
      end else if (sIdx < NS) begin
        inVld = lfsr[3] | lfsr[4];
        inData = DW'(samp[sIdx]);
      end else begin
        inVld = 1'b0;
      end
      prevStall = mBusy && !outRdy;
      prevData = outData;
      // advance model to the state after the coming edge
      if (!mBusy && inVld) begin
        for (int i = N0; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = longint'(samp[sIdx]);
        sIdx++;
        mBusy = 1;
        mPhase = 0;
      end else if (mBusy && outRdy) begin
        if (mPhase == M - 1) mBusy = 0;
        else mPhase++;
      end
    end
  end
endmodule